// File: doc/BRIEF.md
# PLL-Gated Reference Tick Divider

This block turns one base tick train (single-cycle enable pulses at a steady period) into two peripheral reference tick trains. Three synthetic PLL stages each build a source train from the base tick. A stage can pass the base tick straight through (bypass), stay silent (held in reset or powered down), or emit M evenly spread ticks per base period, where M is its multiplier field. A shared reference control word picks one stage through a 2-bit select, divides that train by a 6-bit divisor and gates each of the two outputs with its own enable bit.

The outputs are clock-enable pulses, not clock nets. Downstream logic advances on every cycle in which its tick is high. The control words are plain inputs, and the outputs follow any change to them without a separate update command. A stage learns the base period by counting cycles between base ticks, so the first two base ticks after reset only train it.

Top module: `pll_refclk_top`

## Requirements
- R1: The stage control word has these fields: bit 0 is stage reset, bit 1 is power-down, bit 4 is bypass force, and bits [18:12] hold the 7-bit multiplier M. Bit 3 (bypass qualify) and all other bits have no effect on the output.
- R2: When bypass force is 1, the stage emits the base tick unchanged, whatever bits 0 and 1 hold.
- R3: When bypass force is 0 and either stage reset or power-down is 1, the stage emits no ticks.
- R4: Otherwise, once two base ticks have been seen, the stage emits exactly M ticks in every window of P consecutive cycles, where P is the base period and 1 <= M <= P.
- R5: A non-bypassed stage whose multiplier field is 0 emits no ticks.
- R6: The reference control word bits [5:4] select the source: codes 0 and 1 pick stage 0 (port pll0_ctrl), code 2 picks stage 1, and code 3 picks stage 2.
- R7: Reference control bits [13:8] hold divisor D. When D is 1 to 63, one output tick is produced for every D source ticks. D = 0 passes every source tick.
- R8: Reference control bit 0 enables output ref_tick[0] and bit 1 enables ref_tick[1]. A cleared enable keeps its output low.
- R9: While rst_n is low, both outputs are low. After rst_n rises, they stay low for two further clock edges.
- R10: Any change of the select or divisor field restarts the divide count. After the change, the first output tick comes on the D-th source tick and never earlier.
- R11: An output tick goes high on the clock edge that samples the source tick that produced it, and stays high for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_tick | input | 1 | Base tick train, one-cycle pulses |
| pll0_ctrl | input | 32 | Stage 0 control word (select codes 0 and 1) |
| pll1_ctrl | input | 32 | Stage 1 control word (select code 2) |
| pll2_ctrl | input | 32 | Stage 2 control word (select code 3) |
| ref_ctrl | input | 32 | Reference control: enables, select, divisor |
| ref_tick | output | 2 | Reference tick outputs |

## Verification
The path from the stages through the mux to the divider is combinational. The only register on the way to each output is the output flop, so an output rises on the same edge that samples the producing source tick. The bench checks this by waiting one time unit past that edge. Rate checks count output ticks at falling edges over windows of exactly P·D cycles, which always hold exactly M ticks whatever the phase. Each configuration change is followed by a settle gap of at least two base periods, and three periods after reset so the period counters are trained. The restart check lines the change up with the base tick and counts over windows that end between known tick times. The reset check counts over a window held entirely inside reset.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int CTRL_W      = 32;
  localparam int NUM_PLL     = 3;
  localparam int NUM_OUT     = 2;
  // stage control word fields
  localparam int PLL_RST_BIT = 0;
  localparam int PLL_PD_BIT  = 1;
  localparam int PLL_BYP_BIT = 4;
  localparam int PLL_MUL_LSB = 12;
  localparam int MUL_W       = 7;
  // reference control word fields
  localparam int EN_LSB      = 0;
  localparam int SEL_LSB     = 4;
  localparam int SEL_W       = 2;
  localparam int DIV_LSB     = 8;
  localparam int DIV_W       = 6;

  localparam int PIDX_W      = $clog2(NUM_PLL);

  // two select codes share stage 0
  function automatic logic [PIDX_W-1:0] sel_to_pll(input logic [SEL_W-1:0] s);
    case (s)
      2'd2:    return PIDX_W'(1);
      2'd3:    return PIDX_W'(2);
      default: return PIDX_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/refclk_pll_stage.sv
module refclk_pll_stage
  import refclk_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              tick_o
);
  localparam logic [PER_W-1:0] PER_MAX = '1;

  logic [PER_W-1:0] cnt_q, cnt_d, per_q, per_d, acc_q, acc_d;
  logic [PER_W:0]   sum, mult_x, per_x;
  logic [MUL_W-1:0] mult;
  logic             bypass, halted, hit;
  logic             unused_fields;

  assign unused_fields = ^{ctrl[CTRL_W-1:PLL_MUL_LSB+MUL_W], ctrl[PLL_MUL_LSB-1:PLL_BYP_BIT+1],
                           ctrl[PLL_BYP_BIT-1:PLL_PD_BIT+1]};

  assign mult   = ctrl[PLL_MUL_LSB +: MUL_W];
  assign bypass = ctrl[PLL_BYP_BIT];
  assign halted = ctrl[PLL_RST_BIT] | ctrl[PLL_PD_BIT] | (mult == '0) | (per_q == '0);

  // phase accumulator: M steps per cycle, wrap at the measured period
  assign mult_x = (PER_W+1)'(mult);
  assign per_x  = {1'b0, per_q};
  assign sum    = {1'b0, acc_q} + mult_x;
  assign hit    = (sum >= per_x);

  assign tick_o = bypass ? base_tick : (~halted & hit);

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    if (base_tick) begin
      cnt_d = '0;
      per_d = (cnt_q == PER_MAX) ? PER_MAX : cnt_q + 1'b1;
    end else if (cnt_q != PER_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (bypass || halted) acc_d = '0;
    else if (hit)         acc_d = PER_W'(sum - per_x);
    else                  acc_d = sum[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
  import refclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  output logic             pulse_o
);
  logic [SEL_W+DIV_W-1:0] cfg, cfg_q;
  logic [DIV_W-1:0]       cnt_q, cnt_d, dmax;
  logic                   changed, at_end;

  assign cfg     = {sel, div};
  assign changed = (cfg != cfg_q);
  assign dmax    = (div == '0) ? '0 : div - 1'b1;
  assign at_end  = (cnt_q >= dmax);
  assign pulse_o = src_tick & at_end & ~changed;

  always_comb begin
    if (changed)       cnt_d = '0;
    else if (src_tick) cnt_d = at_end ? '0 : cnt_q + 1'b1;
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cfg_q <= cfg;
    end
  end
endmodule

// File: rtl/pll_refclk_top.sv
module pll_refclk_top
  import refclk_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_tick,
  input  logic [CTRL_W-1:0]  pll0_ctrl,
  input  logic [CTRL_W-1:0]  pll1_ctrl,
  input  logic [CTRL_W-1:0]  pll2_ctrl,
  input  logic [CTRL_W-1:0]  ref_ctrl,
  output logic [NUM_OUT-1:0] ref_tick
);
  logic [1:0]                     rs_q;
  logic                           rst_int_n;
  logic [NUM_PLL-1:0][CTRL_W-1:0] pll_ctrl;
  logic [NUM_PLL-1:0]             pll_tick;
  logic                           src_tick, div_pulse;
  logic [SEL_W-1:0]               sel;
  logic [NUM_OUT-1:0]             ref_d, ref_q;
  logic                           unused_ref;

  assign unused_ref = ^{ref_ctrl[CTRL_W-1:DIV_LSB+DIV_W], ref_ctrl[DIV_LSB-1:SEL_LSB+SEL_W],
                        ref_ctrl[SEL_LSB-1:EN_LSB+NUM_OUT]};

  // asynchronous assert, two-edge synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign pll_ctrl = {pll2_ctrl, pll1_ctrl, pll0_ctrl};

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
    refclk_pll_stage #(.PER_W(PER_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .base_tick (base_tick),
      .ctrl      (pll_ctrl[p]),
      .tick_o    (pll_tick[p])
    );
  end

  assign sel      = ref_ctrl[SEL_LSB +: SEL_W];
  assign src_tick = pll_tick[sel_to_pll(sel)];

  refclk_divider u_div (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .src_tick (src_tick),
    .sel      (sel),
    .div      (ref_ctrl[DIV_LSB +: DIV_W]),
    .pulse_o  (div_pulse)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assign ref_d[g] = div_pulse & ref_ctrl[EN_LSB + g];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ref_q <= '0;
    else            ref_q <= ref_d;
  end

  assign ref_tick = ref_q;
endmodule

// File: rtl/refclk_chk.sv
module refclk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        base_tick,
  input logic [31:0] pll0_ctrl,
  input logic [31:0] ref_ctrl,
  input logic        io_tick,
  input logic [1:0]  ref_tick
);
  logic unused_chk;
  assign unused_chk = ^{pll0_ctrl[31:19], pll0_ctrl[11:5], pll0_ctrl[3:2],
                        ref_ctrl[31:14], ref_ctrl[7:6], ref_ctrl[3:2]};

  // R9: outputs low while reset is asserted
  always @(posedge clk) begin
    if (!rst_n) p_quiet_in_reset_r9: assert (ref_tick == 2'b00);
  end

  p_bypass_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pll0_ctrl[4] |-> (io_tick == base_tick));

  p_halted_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll0_ctrl[4] && (pll0_ctrl[0] || pll0_ctrl[1])) |-> !io_tick);

  p_zero_mult_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll0_ctrl[4] && pll0_ctrl[18:12] == 7'd0) |-> !io_tick);

  p_enable0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ctrl[0] |=> !ref_tick[0]);

  p_enable1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ctrl[1] |=> !ref_tick[1]);

  p_restart_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ({ref_ctrl[13:8], ref_ctrl[5:4]} != $past({ref_ctrl[13:8], ref_ctrl[5:4]})) |=> (ref_tick == 2'b00));

  p_no_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ctrl[13:8] >= 6'd2 && ref_tick[0]) |=> !ref_tick[0]);
endmodule

bind pll_refclk_top refclk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .base_tick (base_tick),
  .pll0_ctrl (pll0_ctrl),
  .ref_ctrl  (ref_ctrl),
  .io_tick   (pll_tick[0]),
  .ref_tick  (ref_tick)
);

// File: tb/sim_pll_refclk_top.sv
`timescale 1ns/1ps
module sim_pll_refclk_top;
  localparam int P = 128;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_tick;
  logic [31:0] pll0_ctrl, pll1_ctrl, pll2_ctrl, ref_ctrl;
  logic [1:0]  ref_tick;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pll_refclk_top u0 (
    .clk (clk), .rst_n (rst_n), .base_tick (base_tick),
    .pll0_ctrl (pll0_ctrl), .pll1_ctrl (pll1_ctrl), .pll2_ctrl (pll2_ctrl),
    .ref_ctrl (ref_ctrl), .ref_tick (ref_tick)
  );

  // base tick generator: one-cycle pulse every P cycles
  initial begin
    base_tick = 1'b0;
    forever begin
      repeat (P - 1) @(negedge clk);
      base_tick = 1'b1;
      @(negedge clk);
      base_tick = 1'b0;
    end
  end

  function automatic logic [31:0] pll_word(bit rst, bit pd, bit qual, bit byp, int m);
    return {13'b0, 7'(m), 7'b0, byp, qual, 1'b0, pd, rst};
  endfunction

  function automatic logic [31:0] ref_word(bit en0, bit en1, int sel, int div);
    return {18'b0, 6'(div), 2'b0, 2'(sel), 2'b0, en1, en0};
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_window(input int w, output int c0, output int c1);
    c0 = 0; c1 = 0;
    repeat (w) begin
      @(negedge clk);
      c0 += int'(ref_tick[0]);
      c1 += int'(ref_tick[1]);
    end
  endtask

  task automatic settle(input int periods);
    repeat (periods * P) @(negedge clk);
  endtask

  task automatic t_reset;
    int c0, c1;
    rst_n = 1'b0;
    pll0_ctrl = pll_word(0, 0, 0, 1, 0);
    ref_ctrl  = ref_word(1, 1, 0, 0);
    count_window(5 * P, c0, c1);
    chk_eq("R9 outputs in reset", c0 + c1, 0);
    @(negedge clk) rst_n = 1'b1;
    settle(3);
    count_window(P, c0, c1);
    chk_eq("R2 bypass after reset out0", c0, 1);
    chk_eq("R2 bypass after reset out1", c1, 1);
  endtask

  task automatic t_multiply;
    int c0, c1;
    pll0_ctrl = pll_word(0, 0, 0, 0, 5);
    ref_ctrl  = ref_word(1, 1, 0, 0);
    settle(2);
    count_window(P, c0, c1);
    chk_eq("R4 R7 multiply x5 out0", c0, 5);
    chk_eq("R4 R7 multiply x5 out1", c1, 5);
  endtask

  task automatic t_select;
    int c0, c1;
    pll1_ctrl = pll_word(0, 0, 0, 0, 9);
    pll2_ctrl = pll_word(0, 0, 0, 0, 3);
    ref_ctrl  = ref_word(1, 0, 1, 0);
    settle(2); count_window(P, c0, c1);
    chk_eq("R6 code1 picks stage0", c0, 5);
    ref_ctrl  = ref_word(1, 0, 2, 0);
    settle(2); count_window(P, c0, c1);
    chk_eq("R6 code2 picks stage1", c0, 9);
    ref_ctrl  = ref_word(1, 0, 3, 0);
    settle(2); count_window(P, c0, c1);
    chk_eq("R6 code3 picks stage2", c0, 3);
    pll0_ctrl = pll_word(0, 0, 1, 0, 5);
    ref_ctrl  = ref_word(1, 0, 0, 0);
    settle(2); count_window(P, c0, c1);
    chk_eq("R1 qualify bit ignored", c0, 5);
  endtask

  task automatic t_priority;
    int c0, c1;
    ref_ctrl  = ref_word(1, 0, 0, 0);
    pll0_ctrl = pll_word(1, 1, 0, 1, 5);
    settle(2); count_window(P, c0, c1);
    chk_eq("R2 bypass beats reset and power-down", c0, 1);
    pll0_ctrl = pll_word(1, 0, 0, 0, 5);
    settle(2); count_window(P, c0, c1);
    chk_eq("R3 stage reset silences", c0, 0);
    pll0_ctrl = pll_word(0, 1, 0, 0, 5);
    settle(2); count_window(P, c0, c1);
    chk_eq("R3 power-down silences", c0, 0);
    pll0_ctrl = pll_word(0, 0, 0, 0, 0);
    settle(2); count_window(P, c0, c1);
    chk_eq("R5 zero multiplier silences", c0, 0);
  endtask

  task automatic t_divide;
    int c0, c1;
    pll0_ctrl = pll_word(0, 0, 0, 0, 12);
    ref_ctrl  = ref_word(1, 0, 0, 4);
    settle(2); count_window(4 * P, c0, c1);
    chk_eq("R7 divide by 4", c0, 12);
    ref_ctrl  = ref_word(1, 0, 0, 1);
    settle(2); count_window(P, c0, c1);
    chk_eq("R7 divide by 1", c0, 12);
    pll0_ctrl = pll_word(0, 0, 0, 0, 63);
    ref_ctrl  = ref_word(1, 0, 0, 63);
    settle(2); count_window(63 * P, c0, c1);
    chk_eq("R7 divide by 63", c0, 63);
  endtask

  task automatic t_enable;
    int c0, c1;
    pll0_ctrl = pll_word(0, 0, 0, 0, 5);
    ref_ctrl  = ref_word(1, 0, 0, 0);
    settle(2); count_window(P, c0, c1);
    chk_eq("R8 enable0 only: out0", c0, 5);
    chk_eq("R8 enable0 only: out1", c1, 0);
    ref_ctrl  = ref_word(0, 1, 0, 0);
    settle(2); count_window(P, c0, c1);
    chk_eq("R8 enable1 only: out0", c0, 0);
    chk_eq("R8 enable1 only: out1", c1, 5);
  endtask

  task automatic t_latency;
    pll0_ctrl = pll_word(0, 0, 0, 1, 0);
    ref_ctrl  = ref_word(1, 1, 0, 0);
    settle(2);
    do @(posedge clk); while (base_tick !== 1'b1);
    #1;
    chk_eq("R11 output on sampling edge", int'(ref_tick), 3);
  endtask

  task automatic t_restart;
    int c0, c1;
    pll0_ctrl = pll_word(0, 0, 0, 1, 0);
    ref_ctrl  = ref_word(1, 0, 0, 6);
    settle(2);
    do @(negedge clk); while (ref_tick[0] !== 1'b1);
    for (int k = 0; k < 3; k++) begin
      do @(posedge clk); while (base_tick !== 1'b1);
    end
    @(negedge clk) ref_ctrl = ref_word(1, 0, 0, 4);
    count_window(3 * P + P / 2, c0, c1);
    chk_eq("R10 no early tick after divisor change", c0, 0);
    count_window(P, c0, c1);
    chk_eq("R10 tick on fourth source tick", c0, 1);
  endtask

  initial begin
    pll1_ctrl = pll_word(1, 0, 0, 0, 0);
    pll2_ctrl = pll_word(1, 0, 0, 0, 0);
    t_reset();
    t_multiply();
    t_select();
    t_priority();
    t_divide();
    t_enable();
    t_latency();
    t_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule